// File: doc/BRIEF.md
# Address Line Mirror Tester

This block is a self-running hardware engine that hunts for broken memory address lines. A broken address line usually makes two addresses that differ in one bit land on the same physical cell, so a write through one of them shows up when the other is read. The engine is given a region (base byte address and size in bytes) and drives a word-wide synchronous memory port. It probes each address bit from the word-size bit upward, flipping that bit of a test address to form a target, and checks whether the target is a mirror of the test address.

Each run makes two passes. The first uses the region base as the test address. The second uses the last 8-byte-aligned location of the region. Targets that fall outside the region are skipped without any memory access. For every target that stays, the engine reads the target, writes the complement of that value through the test address, reads the target again, and then reads the test address again over the port. If the two fresh reads agree, the target is a mirror. The run does not stop at a failure: every mask of both passes is still probed, and the report holds the first failing mask with its test and target addresses. Choosing which regions to test is left to the logic that starts the engine.

The memory port has one cycle of read latency. Addresses are byte addresses and are expected to be word aligned. The region size is expected to be at least 8 and a multiple of the word size.

Top module: `amt_mirror_tester`

## Requirements
- R1: The probe mask starts at the word size in bytes (4 for 32-bit words), doubles after every probe step, and the pass ends when the mask shifts out of the address width (masks 4, 8, ..., 2048 for a 12-bit address).
- R2: The target of each step is the test address XOR the current mask, and every target access uses exactly that byte address.
- R3: A target is probed only when base <= target < base + size. Otherwise the step makes no memory access.
- R4: For each probed target the port sees, in this order: a read of the target, a write to the test address whose data is the bitwise complement of the value that read returned, a second read of the target, and a read of the test address.
- R5: A target is a mirror when the second target read equals the test-address read that follows it. The run continues through all remaining masks and passes after a mirror is found.
- R6: A run has two passes. The first uses the region base as the test address, and the second uses base + size - 8.
- R7: fail_mask, fail_test_addr and fail_target_addr hold the first mirror found in a run. Later mirrors in the same run do not change them, and fail stays high until the next accepted start.
- R8: busy is high from the cycle after an accepted start until the run ends. done is a single-cycle pulse, one cycle after the final step, while busy is low. start is ignored while busy is high.
- R9: After reset, busy, done, fail and mem_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| base_addr | input | AW | Region base byte address |
| region_size | input | AW+1 | Region size in bytes |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | At least one mirror found in the last run |
| fail_mask | output | AW | XOR mask of the first mirror |
| fail_test_addr | output | AW | Test address of the first mirror |
| fail_target_addr | output | AW | Target address of the first mirror |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |

## Verification
Two events can land in the same cycle: the end-of-run pulse that presents a finished report, and acceptance of a new start request, which clears that report. The bench raises start in the very cycle done is seen. It then checks that the report sampled in that cycle belongs to the finished run, while the following run's access stream and report match a fresh expectation. A start pulse in the middle of a run is checked the same way: the scoreboard's expected access stream would break if the engine restarted.

// File: rtl/amt_pkg.sv
package amt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_RT1,
        S_WR,
        S_RT2,
        S_RA,
        S_CMP
    } amt_state_e;

endpackage

// File: rtl/amt_probe.sv
module amt_probe #(
    parameter int AW = 12
) (
    input  logic [AW-1:0] test_addr,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] base,
    input  logic [AW:0]   region_end,
    output logic [AW-1:0] target,
    output logic          in_range
);

    always_comb begin
        target   = test_addr ^ mask;
        in_range = ({1'b0, target} >= {1'b0, base}) && ({1'b0, target} < region_end);
    end

endmodule

// File: rtl/amt_report.sv
module amt_report #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          hit,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] test_addr,
    input  logic [AW-1:0] target,
    output logic          fail,
    output logic [AW-1:0] fail_mask,
    output logic [AW-1:0] fail_test,
    output logic [AW-1:0] fail_target
);

    typedef struct packed {
        logic          fail;
        logic [AW-1:0] mask;
        logic [AW-1:0] test;
        logic [AW-1:0] target;
    } rep_t;

    rep_t rep_d, rep_q;

    always_comb begin
        rep_d = rep_q;
        if (clear) begin
            rep_d = '0;
        end else if (hit && !rep_q.fail) begin
            rep_d.fail   = 1'b1;
            rep_d.mask   = mask;
            rep_d.test   = test_addr;
            rep_d.target = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rep_q <= '0;
        else        rep_q <= rep_d;
    end

    assign fail        = rep_q.fail;
    assign fail_mask   = rep_q.mask;
    assign fail_test   = rep_q.test;
    assign fail_target = rep_q.target;

    // R7: the first recorded mirror is never overwritten within a run
    p_first_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_q.fail && !clear) |=> (rep_q.fail && $stable(rep_q.mask) && $stable(rep_q.target)));

endmodule

// File: rtl/amt_mirror_tester.sv
module amt_mirror_tester
    import amt_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DW       = 32,
    parameter int TAIL_OFS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [AW:0]   region_size,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_mask,
    output logic [AW-1:0] fail_test_addr,
    output logic [AW-1:0] fail_target_addr,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    localparam int            WORD_BYTES = DW / 8;
    localparam int            WB_LOG     = $clog2(WORD_BYTES);
    localparam logic [AW-1:0] MASK_INIT  = AW'(WORD_BYTES);

    typedef struct packed {
        amt_state_e    st;
        logic          pass;
        logic [AW-1:0] mask;
        logic [AW-1:0] test;
        logic [AW-1:0] base;
        logic [AW:0]   size;
        logic [DW-1:0] t2;
        logic          done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [AW-1:0] target;
    logic          in_range;
    logic [AW:0]   region_end;
    logic          hit;
    logic          clear;

    assign region_end = {1'b0, ctl_q.base} + ctl_q.size;

    amt_probe #(.AW(AW)) u_probe (
        .test_addr  (ctl_q.test),
        .mask       (ctl_q.mask),
        .base       (ctl_q.base),
        .region_end (region_end),
        .target     (target),
        .in_range   (in_range)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        case (ctl_q.st)
            S_IDLE: begin
                if (start) begin
                    ctl_d.st   = S_SCAN;
                    ctl_d.pass = 1'b0;
                    ctl_d.mask = MASK_INIT;
                    ctl_d.test = base_addr;
                    ctl_d.base = base_addr;
                    ctl_d.size = region_size;
                end
            end
            S_SCAN: begin
                if (ctl_q.mask == '0) begin
                    if (!ctl_q.pass) begin
                        ctl_d.pass = 1'b1;
                        ctl_d.mask = MASK_INIT;
                        ctl_d.test = AW'({1'b0, ctl_q.base} + ctl_q.size - (AW+1)'(TAIL_OFS));
                    end else begin
                        ctl_d.st   = S_IDLE;
                        ctl_d.done = 1'b1;
                    end
                end else if (in_range) begin
                    ctl_d.st = S_RT1;
                end else begin
                    ctl_d.mask = ctl_q.mask << 1;
                end
            end
            S_RT1: ctl_d.st = S_WR;
            S_WR:  ctl_d.st = S_RT2;
            S_RT2: ctl_d.st = S_RA;
            S_RA: begin
                ctl_d.t2 = mem_rdata;
                ctl_d.st = S_CMP;
            end
            S_CMP: begin
                ctl_d.mask = ctl_q.mask << 1;
                ctl_d.st   = S_SCAN;
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= S_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign clear = (ctl_q.st == S_IDLE) && start;
    assign hit   = (ctl_q.st == S_CMP) && (mem_rdata == ctl_q.t2);

    amt_report #(.AW(AW)) u_report (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .hit         (hit),
        .mask        (ctl_q.mask),
        .test_addr   (ctl_q.test),
        .target      (target),
        .fail        (fail),
        .fail_mask   (fail_mask),
        .fail_test   (fail_test_addr),
        .fail_target (fail_target_addr)
    );

    always_comb begin
        mem_en    = (ctl_q.st == S_RT1) || (ctl_q.st == S_WR) ||
                    (ctl_q.st == S_RT2) || (ctl_q.st == S_RA);
        mem_we    = (ctl_q.st == S_WR);
        mem_addr  = ((ctl_q.st == S_WR) || (ctl_q.st == S_RA)) ? ctl_q.test : target;
        mem_wdata = ~mem_rdata;
    end

    assign busy = (ctl_q.st != S_IDLE);
    assign done = ctl_q.done;

    // R1: mask is a single bit at or above the word-size bit while running
    p_mask_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($onehot0(ctl_q.mask) && (ctl_q.mask[WB_LOG-1:0] == '0)));

    // R3: a first target read is only issued for an in-region target
    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && ctl_q.st == S_RT1) |->
        ({1'b0, mem_addr} >= {1'b0, ctl_q.base} && {1'b0, mem_addr} < region_end));

    // R4: every write is followed directly by a re-read
    p_reread_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> (mem_en && !mem_we));

    // R8: done is a single-cycle pulse while idle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R9: no memory traffic while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);

endmodule

// File: tb/tb_amt_mirror_tester.sv
module tb_amt_mirror_tester;

    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW:0]   region_size = '0;
    logic          busy, done, fail;
    logic [AW-1:0] fail_mask, fail_test_addr, fail_target_addr;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    always #10 clk = ~clk;

    amt_mirror_tester #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base_addr(base_addr), .region_size(region_size),
        .busy(busy), .done(done), .fail(fail),
        .fail_mask(fail_mask), .fail_test_addr(fail_test_addr),
        .fail_target_addr(fail_target_addr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model with an optional shorted address bit
    logic [DW-1:0] mem_arr [0:1023];
    logic [AW-1:0] alias_mask = '0;
    logic [AW-1:0] phys_addr;
    assign phys_addr = mem_addr & ~alias_mask;

    initial begin
        for (int i = 0; i < 1024; i++) mem_arr[i] = 32'(i) * 32'h9E37_79B9;
    end

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_arr[phys_addr[AW-1:2]] <= mem_wdata;
            else        mem_rdata <= mem_arr[phys_addr[AW-1:2]];
        end
    end

    typedef struct {
        logic [AW-1:0] a;
        logic          w;
    } acc_t;

    typedef struct {
        logic          f;
        logic [AW-1:0] m;
        logic [AW-1:0] t;
        logic [AW-1:0] g;
        int            writes;
    } res_t;

    acc_t exp_acc[$];
    res_t exp_res[$];
    int   checks = 0;
    int   errors = 0;
    int   wr_seen = 0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // driver side: expectations derived from the requirements
    task automatic plan(input logic [AW-1:0] b, input logic [AW:0] sz, input logic [AW-1:0] al);
        res_t r;
        r.f = 1'b0; r.m = '0; r.t = '0; r.g = '0; r.writes = 0;
        for (int p = 0; p < 2; p++) begin
            logic [AW-1:0] t;
            t = (p == 0) ? b : AW'({1'b0, b} + sz - 13'd8);
            for (int k = 2; k < AW; k++) begin
                logic [AW-1:0] m, g;
                m = AW'(1 << k);
                g = t ^ m;
                if ({1'b0, g} >= {1'b0, b} && {1'b0, g} < ({1'b0, b} + sz)) begin
                    exp_acc.push_back('{a: g, w: 1'b0});
                    exp_acc.push_back('{a: t, w: 1'b1});
                    exp_acc.push_back('{a: g, w: 1'b0});
                    exp_acc.push_back('{a: t, w: 1'b0});
                    r.writes++;
                    if (m == al && !r.f) begin
                        r.f = 1'b1; r.m = m; r.t = t; r.g = g;
                    end
                end
            end
        end
        exp_res.push_back(r);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic launch(input logic [AW-1:0] b, input logic [AW:0] sz, input bit mid_pulse);
        base_addr = b;
        region_size = sz;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", int'(busy), 1);
        if (mid_pulse) begin
            repeat (7) @(negedge clk);
            base_addr = 12'h000;
            region_size = 13'h1000;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    // monitor side: pops and compares as the design produces results
    always @(negedge clk) begin
        if (rst_n && mem_en) begin
            if (exp_acc.size() == 0) begin
                check(1'b0, "R3 unexpected access", int'(mem_addr), 0);
            end else begin
                acc_t e;
                e = exp_acc.pop_front();
                check(mem_addr == e.a, "R1/R2/R6 access address", int'(mem_addr), int'(e.a));
                check(mem_we == e.w, "R4 access kind", int'(mem_we), int'(e.w));
            end
            if (mem_we) begin
                wr_seen++;
                check(mem_wdata == ~mem_rdata, "R4 complement write data",
                      int'(mem_wdata), int'(~mem_rdata));
            end
        end
        if (rst_n && done) begin
            if (exp_res.size() == 0) begin
                check(1'b0, "R8 unexpected done", 1, 0);
            end else begin
                res_t r;
                r = exp_res.pop_front();
                check(busy == 1'b0, "R8 idle at done", int'(busy), 0);
                check(fail == r.f, "R5 fail flag", int'(fail), int'(r.f));
                check(wr_seen == r.writes, "R3/R5 probes per run", wr_seen, r.writes);
                if (r.f) begin
                    check(fail_mask == r.m, "R7 fail mask", int'(fail_mask), int'(r.m));
                    check(fail_test_addr == r.t, "R7 fail test addr", int'(fail_test_addr), int'(r.t));
                    check(fail_target_addr == r.g, "R7 fail target addr", int'(fail_target_addr), int'(r.g));
                end
            end
            wr_seen = 0;
        end
    end

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R9 reset busy", int'(busy), 0);
        check(done == 1'b0, "R9 reset done", int'(done), 0);
        check(fail == 1'b0, "R9 reset fail", int'(fail), 0);
        check(mem_en == 1'b0, "R9 reset mem_en", int'(mem_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // whole space, no fault
        alias_mask = '0;
        plan(12'h000, 13'h1000, alias_mask);
        launch(12'h000, 13'h1000, 1'b0);
        wait_done();
        @(negedge clk);
        check(done == 1'b0, "R8 done single pulse", int'(done), 0);

        // small region with skipped high masks, no fault
        plan(12'h100, 13'h0100, alias_mask);
        launch(12'h100, 13'h0100, 1'b0);
        wait_done();

        // shorted bit 6: mirror in both passes, first one kept
        alias_mask = 12'h040;
        plan(12'h000, 13'h1000, alias_mask);
        launch(12'h000, 13'h1000, 1'b0);
        wait_done();

        // shorted bit 11 lies outside the region: skipped, so no mirror
        alias_mask = 12'h800;
        plan(12'h400, 13'h0400, alias_mask);
        launch(12'h400, 13'h0400, 1'b1);
        wait_done();

        // shorted bit 9 inside region; start again in the done cycle
        alias_mask = 12'h200;
        plan(12'h400, 13'h0400, alias_mask);
        launch(12'h400, 13'h0400, 1'b0);
        wait_done();
        check(fail == 1'b1, "R7 report visible in done cycle", int'(fail), 1);
        alias_mask = '0;
        plan(12'h200, 13'h0200, alias_mask);
        base_addr = 12'h200;
        region_size = 13'h0200;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 start accepted in done cycle", int'(busy), 1);
        check(fail == 1'b0, "R7 report cleared by new start", int'(fail), 0);
        wait_done();

        repeat (3) @(negedge clk);
        check(exp_acc.size() == 0, "R4 access queue drained", exp_acc.size(), 0);
        check(exp_res.size() == 0, "R8 result queue drained", exp_res.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule